// File: doc/BRIEF.md
# Conditional Move Condition Evaluator

This block decides whether a conditional floating-point register move is carried out. A move can be guarded by one of three sources. The first is a two-bit floating comparison result taken from one of four fields of the status word. The second is the integer flags, either the 32-bit set or the 64-bit set. The third is a sign and zero test on a 64-bit integer register value. Each source has its own table of conditions and its own invert bit. The block reduces all of this to one "take the move" decision.

The decision is available combinationally on `takeMove` in the same cycle as the inputs. A registered copy follows one cycle after a request is marked with `inValid`. Along with that copy comes a skip strobe. The skip strobe marks the case where the move is false and the instruction must act as a no-op that clears the current-exception field. The move datapath and register-file access sit outside this block.

Top module: `cmov_cond_eval`

## Requirements
- R1: With `srcMode`=0 (floating), the selected field value fcc (0 equal, 1 less, 2 greater, 3 unordered) is tested by `condCode[2:0]`: 0 never, 1 fcc≠0, 2 fcc is 1 or 2, 3 fcc is 1 or 3, 4 fcc=1, 5 fcc is 2 or 3, 6 fcc=2, 7 fcc=3.
- R2: `fccSel` values 0, 1, 2, 3 pick `statusWord` bits 11:10, 33:32, 35:34 and 37:36 respectively. All other status bits have no effect.
- R3: With `srcMode`=1 (32-bit flags), the nibble `ccByte[3:0]` holds N, Z, V, C at bits 3, 2, 1, 0. `condCode[2:0]` tests: 0 never, 1 Z, 2 Z or (N xor V), 3 N xor V, 4 C or Z, 5 C, 6 N, 7 V.
- R4: With `srcMode`=2 (64-bit flags), the same tests apply to `ccByte[7:4]`, and `ccByte[3:0]` has no effect. In mode 1, `ccByte[7:4]` has no effect.
- R5: In modes 0, 1 and 2, `condCode[3]`=1 inverts the outcome of the lower three bits.
- R6: With `srcMode`=3 (register), `condCode[1:0]` tests the signed `regValue`: 0 never, 1 equal to zero, 2 less than or equal to zero, 3 less than zero.
- R7: In mode 3, `condCode[2]`=1 inverts the outcome and `condCode[3]` has no effect.
- R8: `takeMove` follows the inputs with no clock. One clock edge after `inValid`=1, `resultValid` is 1 and `takeMoveQ` equals the decision for that request. After a cycle with `inValid`=0, `resultValid`, `takeMoveQ` and `skipQ` are all 0.
- R9: While `resultValid` is 1, exactly one of `takeMoveQ` and `skipQ` is 1. `skipQ`=1 marks a false condition, which calls for a no-op that clears the current exceptions.
- R10: While `rstN` is low, and after it is released, `resultValid`, `takeMoveQ` and `skipQ` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks a request to be registered |
| srcMode | input | 2 | 0 floating, 1 flags 32-bit, 2 flags 64-bit, 3 register |
| condCode | input | 4 | Condition code (register mode uses bits 2:0) |
| fccSel | input | 2 | Floating condition field select |
| statusWord | input | 64 | Floating status word holding the condition fields |
| ccByte | input | 8 | Integer flags, 64-bit set high nibble, 32-bit set low nibble |
| regValue | input | 64 | Integer register value for the zero tests |
| takeMove | output | 1 | Combinational decision |
| takeMoveQ | output | 1 | Registered decision for a valid request |
| skipQ | output | 1 | Registered no-op/clear-exceptions strobe |
| resultValid | output | 1 | Registered request marker |

## Verification
`takeMove` is due in the same cycle as the inputs, so the bench checks it one time step after it drives them on a falling edge. The registered `takeMoveQ`, `skipQ` and `resultValid` are due one rising edge after the request. The driver queues each expected outcome when it drives a request. The monitor then samples shortly after every rising edge and pops one entry for each `resultValid` it sees. Idle cycles are checked the same way, which confirms that nothing is produced when no request was made.

// File: rtl/cmov_pkg.sv
package cmov_pkg;

  typedef enum logic [1:0] {
    SRC_FCC   = 2'd0,
    SRC_ICC32 = 2'd1,
    SRC_ICC64 = 2'd2,
    SRC_REG   = 2'd3
  } srcMode_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic       selFcc;
    logic       selFlags;
    logic       selReg;
    logic       hiNibble;
    logic       invert;
    logic [2:0] test;
  } condStrobes_t;

endpackage

// File: rtl/cmov_ctrl.sv
module cmov_ctrl
  import cmov_pkg::*;
(
  input  logic [1:0]   srcMode,
  input  logic [3:0]   condCode,
  output condStrobes_t strb
);

  always_comb begin
    strb = '0;
    unique case (srcMode_e'(srcMode))
      SRC_FCC: begin
        strb.selFcc = 1'b1;
        strb.invert = condCode[3];
        strb.test   = condCode[2:0];
      end
      SRC_ICC32, SRC_ICC64: begin
        strb.selFlags = 1'b1;
        strb.hiNibble = (srcMode_e'(srcMode) == SRC_ICC64);
        strb.invert   = condCode[3];
        strb.test     = condCode[2:0];
      end
      default: begin
        // Register tests: two-bit test, bit 2 inverts, bit 3 unused.
        strb.selReg = 1'b1;
        strb.invert = condCode[2];
        strb.test   = {1'b0, condCode[1:0]};
      end
    endcase
  end

endmodule

// File: rtl/cmov_dp.sv
module cmov_dp
  import cmov_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int STATUS_W  = 64,
  parameter int NIB_W     = 4,
  parameter int FCC0_LSB  = 10,
  parameter int FCCN_BASE = 30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  condStrobes_t         strb,
  input  logic [1:0]           fccSel,
  input  logic [STATUS_W-1:0]  statusWord,
  input  logic [2*NIB_W-1:0]   ccByte,
  input  logic [DATA_W-1:0]    regValue,
  output logic                 takeMove,
  output logic                 takeMoveQ,
  output logic                 skipQ,
  output logic                 resultValid
);

  localparam int FCC_FIELDS = 4;
  localparam int FCC_W      = 2;

  // Condition field extraction, one tap per selectable field.
  logic [FCC_W-1:0] fccField [FCC_FIELDS];
  for (genvar i = 0; i < FCC_FIELDS; i++) begin : g_fcc
    localparam int LSB = (i == 0) ? FCC0_LSB : FCCN_BASE + FCC_W * i;
    assign fccField[i] = statusWord[LSB +: FCC_W];
  end

  logic [FCC_W-1:0] fcc;
  assign fcc = fccField[fccSel];

  logic fpHit;
  always_comb begin
    unique case (strb.test)
      3'd1:    fpHit = (fcc != 2'd0);
      3'd2:    fpHit = fcc[0] ^ fcc[1];
      3'd3:    fpHit = fcc[0];
      3'd4:    fpHit = (fcc == 2'd1);
      3'd5:    fpHit = fcc[1];
      3'd6:    fpHit = (fcc == 2'd2);
      3'd7:    fpHit = &fcc;
      default: fpHit = 1'b0;
    endcase
  end

  // Integer flags: N Z V C from bit 3 down.
  logic [NIB_W-1:0] flags;
  assign flags = strb.hiNibble ? ccByte[2*NIB_W-1:NIB_W] : ccByte[NIB_W-1:0];
  logic flN, flZ, flV, flC;
  assign {flN, flZ, flV, flC} = flags[3:0];

  logic intHit;
  always_comb begin
    unique case (strb.test)
      3'd1:    intHit = flZ;
      3'd2:    intHit = flZ | (flN ^ flV);
      3'd3:    intHit = flN ^ flV;
      3'd4:    intHit = flC | flZ;
      3'd5:    intHit = flC;
      3'd6:    intHit = flN;
      3'd7:    intHit = flV;
      default: intHit = 1'b0;
    endcase
  end

  logic isZero, isNeg, regHit;
  assign isZero = (regValue == '0);
  assign isNeg  = regValue[DATA_W-1];
  always_comb begin
    unique case (strb.test[1:0])
      2'd1:    regHit = isZero;
      2'd2:    regHit = isZero | isNeg;
      2'd3:    regHit = isNeg;
      default: regHit = 1'b0;
    endcase
  end

  logic rawHit;
  always_comb begin
    if (strb.selFcc)        rawHit = fpHit;
    else if (strb.selFlags) rawHit = intHit;
    else if (strb.selReg)   rawHit = regHit;
    else                    rawHit = 1'b0;
  end

  assign takeMove = rawHit ^ strb.invert;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      takeMoveQ   <= 1'b0;
      skipQ       <= 1'b0;
    end else begin
      resultValid <= inValid;
      takeMoveQ   <= inValid & takeMove;
      skipQ       <= inValid & ~takeMove;
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resultValid);
  p_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (takeMoveQ == $past(takeMove)));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!resultValid && !takeMoveQ && !skipQ));
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (takeMoveQ != skipQ));

endmodule

// File: rtl/cmov_cond_eval.sv
module cmov_cond_eval
  import cmov_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int STATUS_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [1:0]          srcMode,
  input  logic [3:0]          condCode,
  input  logic [1:0]          fccSel,
  input  logic [STATUS_W-1:0] statusWord,
  input  logic [7:0]          ccByte,
  input  logic [DATA_W-1:0]   regValue,
  output logic                takeMove,
  output logic                takeMoveQ,
  output logic                skipQ,
  output logic                resultValid
);

  condStrobes_t strb;

  cmov_ctrl u_ctrl (
    .srcMode  (srcMode),
    .condCode (condCode),
    .strb     (strb)
  );

  cmov_dp #(
    .DATA_W   (DATA_W),
    .STATUS_W (STATUS_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .strb        (strb),
    .fccSel      (fccSel),
    .statusWord  (statusWord),
    .ccByte      (ccByte),
    .regValue    (regValue),
    .takeMove    (takeMove),
    .takeMoveQ   (takeMoveQ),
    .skipQ       (skipQ),
    .resultValid (resultValid)
  );

  p_fcc_never_r1: assert property (@(posedge clk) disable iff (!rstN)
    (srcMode == 2'd0 && condCode == 4'd0) |-> !takeMove);
  p_flag_always_r5: assert property (@(posedge clk) disable iff (!rstN)
    (srcMode != 2'd3 && condCode == 4'd8) |-> takeMove);
  p_reg_never_r6: assert property (@(posedge clk) disable iff (!rstN)
    (srcMode == 2'd3 && condCode[2:0] == 3'd0) |-> !takeMove);
  p_reg_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (srcMode == 2'd3 && condCode[2:0] == 3'd1 && regValue == '0) |-> takeMove);
  p_reset_r10: assert property (@(posedge clk)
    !rstN |=> (!resultValid && !takeMoveQ && !skipQ));

endmodule

// File: tb/sim_cmov_cond_eval.sv
module sim_cmov_cond_eval;

  localparam time CLK_HALF = 2.5ns;

  typedef struct {
    bit    take;
    string tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  srcMode = '0;
  logic [3:0]  condCode = '0;
  logic [1:0]  fccSel = '0;
  logic [63:0] statusWord = '0;
  logic [7:0]  ccByte = '0;
  logic [63:0] regValue = '0;
  logic        takeMove, takeMoveQ, skipQ, resultValid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  expItem_t sb[$];

  always #CLK_HALF clk = ~clk;

  cmov_cond_eval u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcMode(srcMode),
    .condCode(condCode), .fccSel(fccSel), .statusWord(statusWord),
    .ccByte(ccByte), .regValue(regValue), .takeMove(takeMove),
    .takeMoveQ(takeMoveQ), .skipQ(skipQ), .resultValid(resultValid)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference tables written from the requirements.
  function automatic bit refFcc(input int code, input int xr);
    bit [3:0] mask;
    case (code & 7)
      1: mask = 4'b1110;
      2: mask = 4'b0110;
      3: mask = 4'b1010;
      4: mask = 4'b0010;
      5: mask = 4'b1100;
      6: mask = 4'b0100;
      7: mask = 4'b1000;
      default: mask = 4'b0000;
    endcase
    return mask[xr] ^ code[3];
  endfunction

  function automatic bit refInt(input int code, input bit [3:0] nib);
    bit n = nib[3], z = nib[2], v = nib[1], c = nib[0];
    bit r;
    case (code & 7)
      1: r = z;
      2: r = z || (n != v);
      3: r = (n != v);
      4: r = c || z;
      5: r = c;
      6: r = n;
      7: r = v;
      default: r = 0;
    endcase
    return r ^ code[3];
  endfunction

  function automatic bit refReg(input int code, input logic signed [63:0] val);
    bit r;
    case (code & 3)
      1: r = (val == 0);
      2: r = (val <= 0);
      3: r = (val < 0);
      default: r = 0;
    endcase
    return r ^ code[2];
  endfunction

  task automatic apply(input logic [1:0] m, input logic [3:0] cc, input logic [1:0] sel,
                       input logic [63:0] sw, input logic [7:0] fl, input logic [63:0] rv,
                       input bit exp, input string tag);
    expItem_t it;
    @(negedge clk);
    srcMode = m; condCode = cc; fccSel = sel; statusWord = sw;
    ccByte = fl; regValue = rv; inValid = 1'b1;
    it.take = exp; it.tag = tag;
    sb.push_back(it);
    #1;
    chk(takeMove === exp, {tag, " comb R8"}, 64'(takeMove), 64'(exp));
  endtask

  // Monitor: registered results are due one rising edge after the request.
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      if (resultValid === 1'b1) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8 unexpected result", 64'(resultValid), 64'd0);
        end else begin
          expItem_t it;
          it = sb.pop_front();
          chk(takeMoveQ === it.take, {it.tag, " takeMoveQ R8"}, 64'(takeMoveQ), 64'(it.take));
          chk(skipQ === !it.take, {it.tag, " skipQ R9"}, 64'(skipQ), 64'(!it.take));
        end
      end else begin
        chk(takeMoveQ === 1'b0 && skipQ === 1'b0, "R8 idle outputs",
            64'({takeMoveQ, skipQ}), 64'd0);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int lsbs[4] = '{10, 32, 34, 36};
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(resultValid === 1'b0 && takeMoveQ === 1'b0 && skipQ === 1'b0, "R10 in reset",
        64'({resultValid, takeMoveQ, skipQ}), 64'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk(resultValid === 1'b0 && takeMoveQ === 1'b0 && skipQ === 1'b0, "R10 after release",
        64'({resultValid, takeMoveQ, skipQ}), 64'd0);

    // R1, R2, R5: floating fields, other fields hold the complement
    for (int sel = 0; sel < 4; sel++)
      for (int xr = 0; xr < 4; xr++)
        for (int code = 0; code < 16; code++) begin
          logic [63:0] sw;
          logic [1:0] inv;
          inv = ~2'(xr);
          sw = {32{inv}};
          sw[lsbs[sel] +: 2] = 2'(xr);
          apply(2'd0, 4'(code), 2'(sel), sw, 8'hA5, 64'd0,
                refFcc(code, xr), "R1 R2 R5 fcc");
        end

    // R3, R4, R5: flag sets, the unused nibble holds the complement
    for (int nib = 0; nib < 16; nib++)
      for (int code = 0; code < 16; code++) begin
        logic [3:0] nb;
        nb = 4'(nib);
        apply(2'd1, 4'(code), 2'd0, '1, {~nb, nb}, '1, refInt(code, nb), "R3 R5 icc32");
        apply(2'd2, 4'(code), 2'd0, '1, {nb, ~nb}, '1, refInt(code, nb), "R4 R5 icc64");
      end

    // R6, R7: register tests, bit 3 ignored
    begin
      logic [63:0] vals[5] = '{64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF,
                               64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000};
      for (int k = 0; k < 5; k++)
        for (int code = 0; code < 16; code++)
          apply(2'd3, 4'(code), 2'd3, '1, 8'hFF, vals[k],
                refReg(code, vals[k]), "R6 R7 reg");
    end

    // R8: idle cycles produce nothing
    @(negedge clk); inValid = 1'b0;
    repeat (3) begin
      @(posedge clk); #2;
      chk(resultValid === 1'b0, "R8 no request", 64'(resultValid), 64'd0);
    end
    chk(sb.size() == 0, "R8 all results delivered", 64'(sb.size()), 64'd0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule